// File: doc/BRIEF.md
# Bang-Bang Varactor Control Encoder

This block sits between a phase-frequency detector and the switched-capacitor bank of a bang-bang digital oscillator. It turns the early/late indications from the detector into two control words. The loop filter is built into the capacitor bank itself, so the block has no adder and no multiplier. One control word is a two-bit proportional code that switches one small varactor group for one reference period. The other is an integral state that moves by a single step for each reference period in which the detector reports a clear lead or lag.

Both words are registered on the rising edge of the divided feedback clock, which gives at most one integral step per reference cycle. A parameter selects how the integral state is coded. It can be a saturating binary up/down counter for binary-weighted varactors, a thermometer shift register for equal unit varactors, or a one-hot shift register for graded fine varactors. Several instances with different codings can be combined as coarse, medium and fine tuning sections.

Top module: `vctl_encoder`

## Requirements
- R1: The proportional word is {up AND NOT dn, up XNOR dn}. up=1,dn=0 gives 2'b10 (+1). up=0,dn=1 gives 2'b00 (-1). up=dn gives 2'b01 (0).
- R2: Both words change only at the rising edge of fb_clk and show the up/dn values sampled at that edge, one edge after those values are applied.
- R3: With up=1,dn=0 the integral level rises by one. With up=0,dn=1 it falls by one. With up=dn the integral word keeps its value.
- R4: With MODE=CODE_BIN the integral word is an N-bit unsigned count equal to the level (0 to 2^N-1).
- R5: With MODE=CODE_THERM the integral word has 2^N-1 bits, the lowest "level" bits set and all others clear. A step up sets the bit above the run of ones, and a step down clears the top one.
- R6: With MODE=CODE_ONEHOT the integral word has 2^N bits with exactly one bit set, at bit index equal to the level. A step moves that bit one position.
- R7: The level saturates without wrapping. A step up at the top level (2^N-1) and a step down at level 0 leave the word unchanged.
- R8: A low rst_n at a rising fb_clk edge sets the proportional word to 2'b01 and the integral level to 2^(N-1) in every coding, whatever up and dn are.
- R9: The integral word width is N bits for CODE_BIN, 2^N-1 for CODE_THERM and 2^N for CODE_ONEHOT, and the top level reaches the highest bit of the shift codings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fb_clk | input | 1 | Divided feedback clock; rising edge retimes both words |
| rst_n | input | 1 | Active-low synchronous reset |
| up | input | 1 | Detector lead indication (reference early) |
| dn | input | 1 | Detector lag indication (feedback early) |
| prop_word | output | 2 | Registered proportional code |
| int_word | output | N, 2^N-1 or 2^N | Registered integral state in the selected coding |

## Verification
A wrong integral state shows at int_word one feedback edge after the step that caused it. This includes a lost or doubled step, a wrap at an end, or a broken thermometer or one-hot shape, and once wrong the level stays offset until a reset or a saturation realigns it. A wrong proportional decode is visible one edge after the detector combination that triggers it. The bench therefore drives the same up/dn stream into all three codings and compares every word after every edge against a bench level model, with runs that end in saturation at both ends, a reset in the middle of the run, and a long pseudo-random stream.

// File: rtl/vctl_pkg.sv
package vctl_pkg;

  typedef enum logic [1:0] {
    CODE_BIN    = 2'd0,
    CODE_THERM  = 2'd1,
    CODE_ONEHOT = 2'd2
  } code_e;

  typedef struct packed {
    logic inc;
    logic dec;
  } step_t;

  function automatic int word_bits(code_e mode, int n);
    case (mode)
      CODE_BIN:    return n;
      CODE_THERM:  return (1 << n) - 1;
      default:     return (1 << n);
    endcase
  endfunction

  function automatic int mid_level(int n);
    return 1 << (n - 1);
  endfunction

  function automatic logic [1:0] prop_code(logic up, logic dn);
    return {up & ~dn, ~(up ^ dn)};
  endfunction

  function automatic step_t step_of(logic up, logic dn);
    step_t s;
    s.inc = up & ~dn;
    s.dec = dn & ~up;
    return s;
  endfunction

endpackage

// File: rtl/vctl_prop.sv
module vctl_prop (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up,
  input  logic       dn,
  output logic [1:0] prop_q
);

  logic [1:0] prop_d;

  always_comb prop_d = vctl_pkg::prop_code(up, dn);

  always_ff @(posedge clk) begin
    if (!rst_n) prop_q <= 2'b01;
    else        prop_q <= prop_d;
  end

endmodule

// File: rtl/vctl_bin_ctr.sv
module vctl_bin_ctr #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [N-1:0] q,
  output logic         at_top,
  output logic         at_bot
);

  localparam logic [N-1:0] MID = N'(vctl_pkg::mid_level(N));

  always_comb begin
    at_top = &q;
    at_bot = ~|q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                q <= MID;
    else if (inc && !at_top)   q <= q + 1'b1;
    else if (dec && !at_bot)   q <= q - 1'b1;
  end

endmodule

// File: rtl/vctl_therm_sr.sv
module vctl_therm_sr #(
  parameter int N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic               dec,
  output logic [(1<<N)-2:0]  q,
  output logic               at_top,
  output logic               at_bot
);

  localparam int W    = (1 << N) - 1;
  localparam int HALF = vctl_pkg::mid_level(N);

  function automatic logic [W-1:0] half_full();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i < HALF);
    return r;
  endfunction

  always_comb begin
    at_top = q[W-1];
    at_bot = ~q[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              q <= half_full();
    else if (inc && !at_top) q <= {q[W-2:0], 1'b1};
    else if (dec && !at_bot) q <= {1'b0, q[W-1:1]};
  end

endmodule

// File: rtl/vctl_onehot_sr.sv
module vctl_onehot_sr #(
  parameter int N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic               dec,
  output logic [(1<<N)-1:0]  q,
  output logic               at_top,
  output logic               at_bot
);

  localparam int W    = 1 << N;
  localparam int HALF = vctl_pkg::mid_level(N);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    at_top = q[W-1];
    at_bot = q[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              q <= ONE << HALF;
    else if (inc && !at_top) q <= {q[W-2:0], 1'b0};
    else if (dec && !at_bot) q <= {1'b0, q[W-1:1]};
  end

endmodule

// File: rtl/vctl_integ.sv
module vctl_integ #(
  parameter vctl_pkg::code_e MODE = vctl_pkg::CODE_BIN,
  parameter int N = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  inc,
  input  logic                                  dec,
  output logic [vctl_pkg::word_bits(MODE,N)-1:0] q,
  output logic                                  at_top,
  output logic                                  at_bot
);

  generate
    if (MODE == vctl_pkg::CODE_BIN) begin : g_bin
      vctl_bin_ctr #(.N(N)) u_bin (
        .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec),
        .q(q), .at_top(at_top), .at_bot(at_bot));
    end else if (MODE == vctl_pkg::CODE_THERM) begin : g_therm
      vctl_therm_sr #(.N(N)) u_therm (
        .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec),
        .q(q), .at_top(at_top), .at_bot(at_bot));
    end else begin : g_onehot
      vctl_onehot_sr #(.N(N)) u_onehot (
        .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec),
        .q(q), .at_top(at_top), .at_bot(at_bot));
    end
  endgenerate

endmodule

// File: rtl/vctl_encoder.sv
module vctl_encoder #(
  parameter vctl_pkg::code_e MODE = vctl_pkg::CODE_BIN,
  parameter int N = 4
) (
  input  logic                                   fb_clk,
  input  logic                                   rst_n,
  input  logic                                   up,
  input  logic                                   dn,
  output logic [1:0]                             prop_word,
  output logic [vctl_pkg::word_bits(MODE,N)-1:0] int_word
);

  vctl_pkg::step_t step;
  logic            step_up;
  logic            step_dn;
  logic            sat_hi;
  logic            sat_lo;

  always_comb begin
    step    = vctl_pkg::step_of(up, dn);
    step_up = step.inc;
    step_dn = step.dec;
  end

  vctl_prop u_prop (
    .clk(fb_clk), .rst_n(rst_n), .up(up), .dn(dn), .prop_q(prop_word));

  vctl_integ #(.MODE(MODE), .N(N)) u_integ (
    .clk(fb_clk), .rst_n(rst_n), .inc(step_up), .dec(step_dn),
    .q(int_word), .at_top(sat_hi), .at_bot(sat_lo));

endmodule

// File: rtl/vctl_encoder_chk.sv
module vctl_encoder_chk #(
  parameter vctl_pkg::code_e MODE = vctl_pkg::CODE_BIN,
  parameter int N = 4
) (
  input logic                                   fb_clk,
  input logic                                   rst_n,
  input logic                                   up,
  input logic                                   dn,
  input logic [1:0]                             prop_word,
  input logic [vctl_pkg::word_bits(MODE,N)-1:0] int_word,
  input logic                                   sat_hi,
  input logic                                   sat_lo
);

  localparam int W    = vctl_pkg::word_bits(MODE, N);
  localparam int MAXL = (1 << N) - 1;
  localparam int MID  = vctl_pkg::mid_level(N);

  int lvl;

  always_comb begin
    lvl = 0;
    if (MODE == vctl_pkg::CODE_BIN) begin
      lvl = int'(int_word);
    end else if (MODE == vctl_pkg::CODE_THERM) begin
      lvl = $countones(int_word);
    end else begin
      for (int i = 0; i < W; i++) if (int_word[i]) lvl = i;
    end
  end

  p_prop_up_r1: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (up && !dn) |=> (prop_word == 2'b10));
  p_prop_dn_r1: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (!up && dn) |=> (prop_word == 2'b00));
  p_prop_eq_r1: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (up == dn) |=> (prop_word == 2'b01));

  p_hold_r3: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (up == dn) |=> $stable(int_word));
  p_step_up_r3: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (up && !dn && !sat_hi) |=> (lvl == $past(lvl) + 1));
  p_step_dn_r3: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (!up && dn && !sat_lo) |=> (lvl == $past(lvl) - 1));

  p_sat_hi_r7: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (up && !dn && sat_hi) |=> $stable(int_word));
  p_sat_lo_r7: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (!up && dn && sat_lo) |=> $stable(int_word));
  p_sat_flags_r7: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (sat_hi == (lvl == MAXL)) && (sat_lo == (lvl == 0)));

  p_reset_r8: assert property (@(posedge fb_clk)
    !rst_n |=> ((prop_word == 2'b01) && (lvl == MID)));

  generate
    if (MODE == vctl_pkg::CODE_THERM) begin : g_therm_chk
      p_therm_shape_r5: assert property (@(posedge fb_clk) disable iff (!rst_n)
        (((int_word + W'(1)) & int_word) == '0));
    end else if (MODE == vctl_pkg::CODE_ONEHOT) begin : g_onehot_chk
      p_onehot_r6: assert property (@(posedge fb_clk) disable iff (!rst_n)
        ($countones(int_word) == 1));
    end
  endgenerate

endmodule

bind vctl_encoder vctl_encoder_chk #(.MODE(MODE), .N(N)) u_chk (
  .fb_clk(fb_clk), .rst_n(rst_n), .up(up), .dn(dn),
  .prop_word(prop_word), .int_word(int_word),
  .sat_hi(sat_hi), .sat_lo(sat_lo));

// File: tb/test_vctl_encoder.sv
module test_vctl_encoder;

  localparam int N    = 3;
  localparam int BW   = N;
  localparam int TW   = (1 << N) - 1;
  localparam int OW   = 1 << N;
  localparam int MAXL = (1 << N) - 1;
  localparam int MID  = 1 << (N - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          up = 1'b0;
  logic          dn = 1'b0;
  logic [1:0]    p_bin, p_th, p_oh;
  logic [BW-1:0] w_bin;
  logic [TW-1:0] w_th;
  logic [OW-1:0] w_oh;

  int  checks = 0;
  int  fails  = 0;
  int  lvl    = MID;
  bit  done   = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  vctl_encoder #(.MODE(vctl_pkg::CODE_BIN), .N(N)) i_vctl_encoder (
    .fb_clk(clk), .rst_n(rst_n), .up(up), .dn(dn),
    .prop_word(p_bin), .int_word(w_bin));
  vctl_encoder #(.MODE(vctl_pkg::CODE_THERM), .N(N)) i_vctl_encoder_th (
    .fb_clk(clk), .rst_n(rst_n), .up(up), .dn(dn),
    .prop_word(p_th), .int_word(w_th));
  vctl_encoder #(.MODE(vctl_pkg::CODE_ONEHOT), .N(N)) i_vctl_encoder_oh (
    .fb_clk(clk), .rst_n(rst_n), .up(up), .dn(dn),
    .prop_word(p_oh), .int_word(w_oh));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (level %0d)", req, act, exp, lvl);
    end
  endtask

  task automatic step(logic u, logic d, logic r, string tag);
    logic [1:0] ep;
    @(negedge clk);
    up = u; dn = d; rst_n = r;
    @(posedge clk);
    if (!r) begin
      lvl = MID;
      ep  = 2'b01;
    end else begin
      if (u && !d && lvl < MAXL) lvl++;
      else if (d && !u && lvl > 0) lvl--;
      ep = (u && !d) ? 2'b10 : ((d && !u) ? 2'b00 : 2'b01);
    end
    #1;
    chk({tag, " R1 R2 prop bin"}, 32'(p_bin), 32'(ep));
    chk({tag, " R1 prop therm"},  32'(p_th),  32'(ep));
    chk({tag, " R1 prop onehot"}, 32'(p_oh),  32'(ep));
    chk({tag, " R3 R4 bin word"},    32'(w_bin), 32'(lvl));
    chk({tag, " R3 R5 therm word"},  32'(w_th),  32'((1 << lvl) - 1));
    chk({tag, " R3 R6 onehot word"}, 32'(w_oh),  32'(1 << lvl));
  endtask

  initial begin
    step(1'b0, 1'b0, 1'b0, "R8 reset");
    step(1'b1, 1'b0, 1'b0, "R8 reset ignores up");
    step(1'b0, 1'b0, 1'b1, "R3 hold 00");
    step(1'b1, 1'b1, 1'b1, "R3 hold 11");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, "R7 R9 climb");
    chk("R7 R9 top thermo full", 32'(w_th), 32'((1 << TW) - 1));
    chk("R7 R9 top onehot msb", 32'(w_oh[OW-1]), 32'd1);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, "R7 descend");
    chk("R7 bottom bin zero", 32'(w_bin), 32'd0);
    for (int i = 0; i < 8; i++) step(i[0], ~i[0], 1'b1, "R3 alternate");
    step(1'b1, 1'b0, 1'b1, "R3 up");
    step(1'b1, 1'b0, 1'b0, "R8 midrun reset");
    step(1'b0, 1'b1, 1'b1, "R3 after reset");
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[5], 1'b1, "R2 R3 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule